// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a half-duplex synchronous serial port that acts as clock master. It makes the shift clock itself, using a programmable divider of the system clock. It samples the serial data line once per bit and builds 8-bit or 9-bit words, least significant bit first. Each finished word is placed in a holding register that the CPU reads. A completion flag and an optional interrupt request report each finished word.

Software works the block through four word-wide registers:

- **Control (address 0):** bit 0 enables the master mode, bit 1 requests a single word, bit 2 requests continuous reception, bit 3 selects 9-bit words, bit 4 sets the idle level of the clock pin, and bit 5 enables the interrupt.
- **Divisor (address 1):** holds the divisor.
- **Status (address 2):** bit 0 is the ninth bit, bit 1 is overrun, and bit 2 is the completion flag. Reading it has no side effect.
- **Data (address 3):** holds the received byte in bits 7:0. A read strobe at this address clears the completion flag.

The read data bus follows the address combinationally. Writes and read side effects take place at the rising clock edge where the strobe is sampled.

Top module: `sync_master_rx`

## Requirements
- R1: After reset all registers read as zero, the clock pin is low and the interrupt output is low.
- R2: The clock pin stays at its idle level, and no word is received, unless master mode (control bit 0) is set and at least one of the single (bit 1) or continuous (bit 2) enables is set.
- R3: Each half of the shift clock lasts divisor+1 system cycles. The completion flag of the first word is set 2·B·(divisor+1) rising edges after the edge that samples the enabling control write, where B is 8 or 9.
- R4: The data line is sampled at the trailing edge of each active clock pulse (a falling edge when the clock idles low). The first bit sampled lands in data bit 0.
- R5: In single mode exactly one word is clocked in. Control bit 1 then clears itself, and the clock pin returns to its idle level.
- R6: In continuous mode words are received back to back, in order, until bit 2 is cleared. While both enables are set, continuous mode governs and bit 1 is not cleared.
- R7: With control bit 3 set, a ninth bit is received after the byte and is reported in status bit 0. In 8-bit mode status bit 0 reads 0.
- R8: Status bit 2 is set when a word completes and is cleared by a data-register read. The interrupt output equals that flag ANDed with control bit 5.
- R9: A word that completes while status bit 2 is still set sets overrun (status bit 1) and is discarded. The holding register keeps the earlier word.
- R10: A control write with bit 2 equal to 0 clears overrun on that edge.
- R11: The clock pin idles at the level of control bit 4 and pulses to the opposite level while receiving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at the data address) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | RW | Write data |
| reg_rdata | output | RW | Read data, combinational from the address |
| sclk_o | output | 1 | Generated shift clock |
| sdata_i | input | 1 | Serial data input |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A finished word raises the completion flag and the interrupt 2·B·(divisor+1) rising edges after the enabling write. The bench counts edges from that write and samples the interrupt one edge before and at the due edge. Status and data are read with the strobe set up at a falling edge, and the bus value is sampled combinationally before the next rising edge. The clearing effect of a data read or a control write is therefore first checked through the next register read, which follows the side-effect edge. The serial slave model changes the data line on each leading clock edge. It stays half a clock period away from the sampling edge, so each expected word in the scoreboard queue is compared against what the design assembles from exactly those bits.

// File: rtl/smrx_pkg.sv
package smrx_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_DIV  = 2'd1,
      REG_STAT = 2'd2,
      REG_DATA = 2'd3
   } reg_sel_e;

   // control field positions (software visible)
   localparam int unsigned C_MASTER = 0;
   localparam int unsigned C_SINGLE = 1;
   localparam int unsigned C_CONT   = 2;
   localparam int unsigned C_NINE   = 3;
   localparam int unsigned C_POL    = 4;
   localparam int unsigned C_IRQEN  = 5;
   localparam int unsigned CTRL_W   = 6;

   // status field positions
   localparam int unsigned S_NINTH  = 0;
   localparam int unsigned S_OVR    = 1;
   localparam int unsigned S_DONE   = 2;

   typedef struct packed {
      logic irq_en;
      logic pol;
      logic nine;
      logic cont;
      logic single;
      logic master;
   } ctrl_t;

endpackage

// File: rtl/smrx_clkgen.sv
module smrx_clkgen #(
   parameter int unsigned DIVW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] divisor,
   output logic            hi,
   output logic            sample_stb
);

   generate
      if (DIVW < 1) begin : g_bad_divw
         $error("smrx_clkgen: DIVW must be at least 1");
      end
   endgenerate

   logic [DIVW-1:0] cnt_q;
   logic            hi_q;
   logic            term;

   assign term = (cnt_q >= divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         hi_q  <= ~hi_q;
      end else begin
         cnt_q <= cnt_q + DIVW'(1);
      end
   end

   assign hi         = hi_q;
   assign sample_stb = run & term & hi_q;

endmodule

// File: rtl/smrx_shifter.sv
module smrx_shifter #(
   parameter int unsigned DW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        sample_stb,
   input  logic        nine,
   input  logic        sdata,
   output logic        word_done,
   output logic [DW:0] word
);

   localparam int unsigned CW = $clog2(DW + 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("smrx_shifter: DW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] bcnt_q;
   logic [DW:0]   sh_q;
   logic [DW:0]   nxt;
   logic [CW-1:0] last;

   assign last = nine ? CW'(DW) : CW'(DW - 1);

   // next shift image: current bit lands at its index, a fresh word clears the rest
   for (genvar i = 0; i <= DW; i++) begin : g_bit
      assign nxt[i] = (bcnt_q == CW'(i)) ? sdata :
                      ((bcnt_q == '0) ? 1'b0 : sh_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
      end else if (!run) begin
         bcnt_q <= '0;
      end else if (sample_stb) begin
         if (bcnt_q == last) bcnt_q <= '0;
         else                bcnt_q <= bcnt_q + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sh_q <= '0;
      else if (sample_stb) sh_q <= nxt;
   end

   assign word_done = sample_stb & (bcnt_q == last);
   assign word      = {nine & nxt[DW], nxt[DW-1:0]};

endmodule

// File: rtl/smrx_regs.sv
module smrx_regs
   import smrx_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned DIVW    = 16,
   parameter int unsigned RW      = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [1:0]      reg_addr,
   input  logic [RW-1:0]   reg_wdata,
   output logic [RW-1:0]   reg_rdata,
   input  logic            word_done,
   input  logic [DW:0]     word,
   output ctrl_t           ctl,
   output logic [DIVW-1:0] divisor,
   output logic            done,
   output logic            ovr,
   output logic [DW-1:0]   hold,
   output logic            irq
);

   generate
      if (RW < DIVW) begin : g_bad_rw_div
         $error("smrx_regs: RW must hold the divisor");
      end
      if (RW < DW) begin : g_bad_rw_dw
         $error("smrx_regs: RW must hold a data word");
      end
      if (RW < CTRL_W) begin : g_bad_rw_ctl
         $error("smrx_regs: RW must hold the control fields");
      end
   endgenerate

   ctrl_t           ctrl_q;
   logic [DIVW-1:0] div_q;
   logic [DW-1:0]   hold_q;
   logic            ninth_q;
   logic            done_q;
   logic            ovr_q;

   logic wr_ctrl, wr_div, rd_data, accept;

   assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
   assign wr_div  = reg_wr && (reg_addr == REG_DIV);
   assign rd_data = reg_rd && (reg_addr == REG_DATA);
   assign accept  = word_done && !done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      end else if (word_done && !ctrl_q.cont) begin
         ctrl_q.single <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (wr_div) div_q <= reg_wdata[DIVW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         ninth_q <= 1'b0;
      end else if (accept) begin
         hold_q  <= word[DW-1:0];
         ninth_q <= word[DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       done_q <= 1'b0;
      else if (accept)  done_q <= 1'b1;
      else if (rd_data) done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ovr_q <= 1'b0;
      else if (wr_ctrl && !reg_wdata[C_CONT])  ovr_q <= 1'b0;
      else if (word_done && done_q)            ovr_q <= 1'b1;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_addr))
         REG_CTRL: reg_rdata = RW'(ctrl_q);
         REG_DIV:  reg_rdata = RW'(div_q);
         REG_STAT: reg_rdata = RW'({done_q, ovr_q, ninth_q});
         REG_DATA: reg_rdata = RW'(hold_q);
         default:  reg_rdata = '0;
      endcase
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done_q & ctrl_q.irq_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = done_q & ctrl_q.irq_en;
      end
   endgenerate

   assign ctl     = ctrl_q;
   assign divisor = div_q;
   assign done    = done_q;
   assign ovr     = ovr_q;
   assign hold    = hold_q;

endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
   import smrx_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned DIVW    = 16,
   parameter int unsigned RW      = 16,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          sclk_o,
   input  logic          sdata_i,
   output logic          irq_o
);

   ctrl_t           ctl;
   logic [DIVW-1:0] divisor;
   logic            run;
   logic            clk_hi;
   logic            sample_stb;
   logic            word_done;
   logic [DW:0]     word;
   logic            done;
   logic            ovr;
   logic [DW-1:0]   hold;
   logic            ctl_pol;
   logic            ctl_cont;
   logic            ctl_single;

   assign ctl_pol    = ctl.pol;
   assign ctl_cont   = ctl.cont;
   assign ctl_single = ctl.single;
   assign run        = ctl.master & (ctl_single | ctl_cont);
   assign sclk_o     = clk_hi ^ ctl_pol;

   smrx_clkgen #(.DIVW(DIVW)) u_clkgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .divisor    (divisor),
      .hi         (clk_hi),
      .sample_stb (sample_stb)
   );

   smrx_shifter #(.DW(DW)) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .sample_stb (sample_stb),
      .nine       (ctl.nine),
      .sdata      (sdata_i),
      .word_done  (word_done),
      .word       (word)
   );

   smrx_regs #(.DW(DW), .DIVW(DIVW), .RW(RW), .IRQ_REG(IRQ_REG)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .word_done  (word_done),
      .word       (word),
      .ctl        (ctl),
      .divisor    (divisor),
      .done       (done),
      .ovr        (ovr),
      .hold       (hold),
      .irq        (irq_o)
   );

endmodule

// File: rtl/smrx_chk.sv
module smrx_chk #(
   parameter int unsigned DW   = 8,
   parameter int unsigned DIVW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            hi,
   input logic            sclk_o,
   input logic            pol,
   input logic            cont,
   input logic            single,
   input logic [DIVW-1:0] divisor,
   input logic            done,
   input logic            ovr,
   input logic [DW-1:0]   hold,
   input logic            reg_wr,
   input logic [1:0]      reg_addr,
   input logic            wdata_cont
);

   localparam int unsigned PW = DIVW + 1;

   logic [PW-1:0] pcnt;
   logic          hi_d;
   logic          wr_ctrl;

   assign wr_ctrl = reg_wr && (reg_addr == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         hi_d <= 1'b0;
      end else begin
         hi_d <= hi;
         if (!run)             pcnt <= '0;
         else if (hi != hi_d)  pcnt <= PW'(1);
         else                  pcnt <= pcnt + PW'(1);
      end
   end

   // R2
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> (sclk_o == pol));

   // R3
   phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (hi != hi_d)) |-> (pcnt == ({1'b0, divisor} + PW'(1))));

   // R4
   trailing_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(hi) && !hi));

   // R5
   single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && !$past(cont) && !$past(wr_ctrl)) |-> !single);

   // R9
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(hold));

   // R10
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata_cont) |=> !ovr);

endmodule

bind sync_master_rx smrx_chk #(.DW(DW), .DIVW(DIVW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .hi         (clk_hi),
   .sclk_o     (sclk_o),
   .pol        (ctl_pol),
   .cont       (ctl_cont),
   .single     (ctl_single),
   .divisor    (divisor),
   .done       (done),
   .ovr        (ovr),
   .hold       (hold),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .wdata_cont (reg_wdata[smrx_pkg::C_CONT])
);

// File: tb/sync_master_rx_tb.sv
module sync_master_rx_tb;

   localparam int RW = 16;
   localparam logic [15:0] MASTER = 16'h01, SINGLE = 16'h02, CONT = 16'h04,
                           NINE = 16'h08, POL = 16'h10, IRQEN = 16'h20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [RW-1:0] reg_wdata = '0;
   logic          sdata = 1'b0;
   wire  [RW-1:0] reg_rdata;
   wire           sclk;
   wire           irq;

   always #5 clk = ~clk;

   sync_master_rx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sclk_o    (sclk),
      .sdata_i   (sdata),
      .irq_o     (irq)
   );

   int         checks = 0;
   int         errors = 0;
   logic [8:0] expq[$];
   bit         bitq[$];
   logic       pol_b = 1'b0;
   int         lead_cnt = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // serial slave: presents the next bit on every leading clock edge
   always @(sclk) begin
      if (sclk === ~pol_b) begin
         lead_cnt++;
         if (bitq.size() > 0) sdata = bitq.pop_front();
         else                 sdata = 1'b0;
      end
   end

   task automatic reg_write(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // driver: queue serial bits and the expected word
   task automatic push_word(logic [8:0] v, bit nine, bit expect_it);
      for (int i = 0; i < (nine ? 9 : 8); i++) bitq.push_back(v[i]);
      if (expect_it) expq.push_back(nine ? v : {1'b0, v[7:0]});
   endtask

   task automatic wait_irq(string req);
      int n = 0;
      while (irq !== 1'b1 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      if (irq !== 1'b1) chk({req, " irq timeout"}, 0, 1);
   endtask

   // monitor: pop expected words and compare with what the design delivers
   task automatic collect(int n, string req);
      logic [15:0] s, d;
      logic [8:0]  e;
      for (int k = 0; k < n; k++) begin
         wait_irq(req);
         reg_read(2'd2, s);
         reg_read(2'd3, d);
         e = (expq.size() > 0) ? expq.pop_front() : 9'h1FF;
         chk({req, " done flag"}, int'(s[2]), 1);
         chk({req, " ninth bit"}, int'(s[0]), int'(e[8]));
         chk({req, " data"}, int'(d[7:0]), int'(e[7:0]));
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 sclk", int'(sclk), 0);
      chk("R1 irq", int'(irq), 0);
      reg_read(2'd0, v); chk("R1 ctrl", int'(v), 0);
      reg_read(2'd1, v); chk("R1 div", int'(v), 0);
      reg_read(2'd2, v); chk("R1 stat", int'(v), 0);

      // R2 no clocking without master mode or without an enable
      lead_cnt = 0;
      reg_write(2'd0, SINGLE | CONT);
      repeat (100) @(negedge clk);
      chk("R2 no master edges", lead_cnt, 0);
      chk("R2 sclk idle", int'(sclk), 0);
      reg_write(2'd0, MASTER);
      repeat (100) @(negedge clk);
      chk("R2 no enable edges", lead_cnt, 0);
      reg_read(2'd2, v); chk("R2 stat", int'(v), 0);

      // R3 R4 R5 single word, divisor 3, exact completion cycle
      reg_write(2'd1, 16'd3);
      push_word(9'h0A5, 1'b0, 1'b1);
      lead_cnt = 0;
      reg_write(2'd0, MASTER | SINGLE | IRQEN);
      repeat (63) @(posedge clk);
      @(negedge clk);
      chk("R3 not yet done", int'(irq), 0);
      @(negedge clk);
      chk("R3 done on time", int'(irq), 1);
      collect(1, "R4");
      reg_read(2'd0, v); chk("R5 single self-clear", int'(v[1]), 0);
      repeat (50) @(negedge clk);
      chk("R5 one word of edges", lead_cnt, 8);
      chk("R5 sclk idle", int'(sclk), 0);
      reg_read(2'd2, v); chk("R8 done cleared by read", int'(v[2]), 0);

      // R7 nine-bit words
      reg_write(2'd1, 16'd1);
      push_word(9'h15A, 1'b1, 1'b1);
      reg_write(2'd0, MASTER | SINGLE | NINE | IRQEN);
      collect(1, "R7");
      push_word(9'h0C3, 1'b1, 1'b1);
      reg_write(2'd0, MASTER | SINGLE | NINE | IRQEN);
      collect(1, "R7");

      // R11 inverted clock polarity
      pol_b = 1'b1;
      reg_write(2'd0, POL);
      chk("R11 idle high", int'(sclk), 1);
      reg_write(2'd1, 16'd0);
      push_word(9'h03C, 1'b0, 1'b1);
      lead_cnt = 0;
      reg_write(2'd0, POL | MASTER | SINGLE | IRQEN);
      collect(1, "R11");
      chk("R11 idle after word", int'(sclk), 1);
      chk("R11 active pulses", lead_cnt, 8);
      pol_b = 1'b0;
      reg_write(2'd0, 16'h0);

      // R6 continuous, both enables set
      reg_write(2'd1, 16'd2);
      push_word(9'h011, 1'b0, 1'b1);
      push_word(9'h022, 1'b0, 1'b1);
      push_word(9'h0E7, 1'b0, 1'b1);
      reg_write(2'd0, MASTER | SINGLE | CONT | IRQEN);
      collect(3, "R6");
      reg_read(2'd0, v); chk("R6 single kept under continuous", int'(v[1]), 1);
      reg_write(2'd0, 16'h0);
      bitq.delete();

      // R9 R10 overrun
      reg_write(2'd1, 16'd0);
      push_word(9'h081, 1'b0, 1'b1);
      push_word(9'h042, 1'b0, 1'b0);
      reg_write(2'd0, MASTER | CONT | IRQEN);
      wait_irq("R9");
      repeat (40) @(negedge clk);
      reg_read(2'd2, v); chk("R9 overrun and done", int'(v[2:0]), 6);
      reg_read(2'd3, v); chk("R9 first word kept", int'(v[7:0]), int'(expq.pop_front()));
      reg_write(2'd0, MASTER);
      reg_read(2'd2, v); chk("R10 overrun cleared", int'(v[1]), 0);
      reg_read(2'd3, v);
      bitq.delete();

      // R8 completion without interrupt enable
      push_word(9'h096, 1'b0, 1'b1);
      reg_write(2'd0, MASTER | SINGLE);
      repeat (40) @(negedge clk);
      chk("R8 irq masked", int'(irq), 0);
      reg_read(2'd2, v); chk("R8 done set", int'(v), 4);
      reg_read(2'd3, v); chk("R8 data", int'(v[7:0]), int'(expq.pop_front()));
      reg_read(2'd2, v); chk("R8 done cleared", int'(v), 0);

      summary();
      $finish;
   end

endmodule